// File: doc/BRIEF.md
# Audio Converter DMA Request Generator

This block drives the two DMA request lines of an audio converter on an ISA-style bus. One line serves capture and one serves playback. Each direction is either serviced by DMA or left to programmed I/O, according to an enable bit and a PIO-select bit. A single-channel mode folds capture onto the playback request line. In that mode playback wins when both directions want service.

Each direction keeps a byte counter that is loaded with the transfer length. The counter steps down once for each acknowledged byte. A request rises when the converter signals that a sample is ready. It falls at a point chosen by a timing-mode bit: either the start of the strobe for the byte before the last one, or the end of the strobe for the last byte.

When a counter runs out, it reloads and sets an interrupt status bit. The active-high interrupt pin shows that status only while interrupt enable is set.

Top module: `dma_req_gen`

## Requirements
- R1: A capture request can only be raised when `cap_en`=1 and `cap_pio`=0. Only in that state do capture strobes (`bus_rd` high while acknowledged) count against the capture byte counter.
- R2: With `cap_en`=1 and `cap_pio`=1, `cap_drq` stays 0 and capture strobes change no counter and set no interrupt.
- R3: With `cap_en`=0 the capture request is dropped at the next clock edge and stays low.
- R4: Playback raises requests only when `play_en`=1 and `play_pio`=0. With `play_pio`=1, `play_drq` stays 0.
- R5: With `single_chan`=1, capture requests appear on `play_drq`, capture uses `play_ack`, and `cap_drq` is 0. If playback DMA is also enabled, capture is not serviced.
- R6: With `early_rel`=1, the request drops at the clock edge where the strobe is first sampled high (with acknowledge) while two bytes remain.
- R7: With `early_rel`=0, the request drops at the clock edge where the strobe is first sampled low after the last byte (one byte remaining).
- R8: `irq` equals the interrupt status bit while `int_en`=1 and is 0 while `int_en`=0.
- R9: Each completed byte decrements the counter. At the last byte the counter reloads from `xfer_len` and sets the status bit. The status bit stays set until `int_ack` is pulsed.
- R10: After release, a request stays low until the next ready pulse for its direction. A ready pulse raises it at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable |
| cap_pio | input | 1 | Capture uses programmed I/O |
| play_en | input | 1 | Playback enable |
| play_pio | input | 1 | Playback uses programmed I/O |
| single_chan | input | 1 | Fold capture onto the playback request line |
| early_rel | input | 1 | Release on next-to-last byte strobe start |
| int_en | input | 1 | Interrupt pin enable |
| int_ack | input | 1 | Clears interrupt status |
| xfer_len | input | CNT_W | Bytes per transfer (at least 1) |
| cap_ready | input | 1 | Capture sample-ready pulse |
| play_ready | input | 1 | Playback sample-ready pulse |
| cap_ack | input | 1 | Capture DMA acknowledge |
| play_ack | input | 1 | Playback DMA acknowledge |
| bus_rd | input | 1 | Read strobe (capture bytes) |
| bus_wr | input | 1 | Write strobe (playback bytes) |
| cap_drq | output | 1 | Capture DMA request |
| play_drq | output | 1 | Playback DMA request |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench compares the two release points byte by byte.
- A design that used the wrong strobe edge, or the wrong remaining count, would hold the request one byte too long or drop it one byte early.
- A design that counted strobes while capture is set to programmed I/O would raise a stray interrupt.
- A design that left capture on its own line in single-channel mode, or let capture win over playback, would show a request on the wrong pin.
- Gating and clearing of the interrupt are checked, as is the rule that a request stays low after release until a new ready pulse.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
    localparam int DEF_CNT_W = 8;

    typedef struct packed {
        logic en;
        logic pio;
    } dir_cfg_t;

    typedef enum logic {
        REL_LAST_FALL = 1'b0,
        REL_PREV_RISE = 1'b1
    } rel_mode_t;

    function automatic logic dma_on(input dir_cfg_t c);
        return c.en & ~c.pio;
    endfunction
endpackage

// File: rtl/dmarq_chan.sv
module dmarq_chan
    import dmarq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  rel_mode_t        mode,
    input  logic [CNT_W-1:0] len,
    input  logic             ready,
    input  logic             stb,
    input  logic             ack,
    output logic             pend,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt;
    logic             stb_q, ack_q;
    logic             rise, fall, rel, last;

    assign rise = act & stb & ~stb_q & ack;
    assign fall = act & ~stb & stb_q & ack_q;
    assign last = (cnt <= ONE);
    assign tc   = fall & last;

    always_comb begin
        if (mode == REL_PREV_RISE)
            rel = (rise && cnt == TWO) || tc;
        else
            rel = tc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= len;
            stb_q <= 1'b0;
            ack_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            stb_q <= stb;
            ack_q <= ack;
            if (!act) begin
                pend <= 1'b0;
                cnt  <= len;
            end else begin
                if (fall) begin
                    if (last) cnt <= len;
                    else      cnt <= cnt - ONE;
                end
                if (ready)    pend <= 1'b1;
                else if (rel) pend <= 1'b0;
            end
        end
    end

    // R3
    inact_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !act |=> !pend);
    // R7
    last_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && cnt == ONE && !ready) |=> !pend);
    // R6
    prev_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == REL_PREV_RISE && rise && cnt == TWO && !ready) |=> !pend);
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> cnt == $past(len));
    // R9
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && cnt > ONE) |=> cnt == $past(cnt) - ONE);
    // R10
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend && !ready) |=> !pend);
endmodule

// File: rtl/dmarq_irq.sv
module dmarq_irq (
    input  logic clk,
    input  logic rst,
    input  logic tc_cap,
    input  logic tc_play,
    input  logic int_ack,
    input  logic int_en,
    output logic irq
);
    logic status;

    always_ff @(posedge clk) begin
        if (rst)                    status <= 1'b0;
        else if (tc_cap || tc_play) status <= 1'b1;
        else if (int_ack)           status <= 1'b0;
    end

    assign irq = int_en & status;

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !tc_cap && !tc_play) |=> !status);
    // R9
    set_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_cap || tc_play) |=> status);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import dmarq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             cap_pio,
    input  logic             play_en,
    input  logic             play_pio,
    input  logic             single_chan,
    input  logic             early_rel,
    input  logic             int_en,
    input  logic             int_ack,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             cap_ready,
    input  logic             play_ready,
    input  logic             cap_ack,
    input  logic             play_ack,
    input  logic             bus_rd,
    input  logic             bus_wr,
    output logic             cap_drq,
    output logic             play_drq,
    output logic             irq
);
    dir_cfg_t  cap_cfg, play_cfg;
    rel_mode_t mode;
    logic      play_act, cap_act, cap_ack_sel;
    logic      cap_pend, play_pend, cap_tc, play_tc;

    assign cap_cfg  = '{en: cap_en, pio: cap_pio};
    assign play_cfg = '{en: play_en, pio: play_pio};
    assign mode     = early_rel ? REL_PREV_RISE : REL_LAST_FALL;

    assign play_act    = dma_on(play_cfg);
    assign cap_act     = dma_on(cap_cfg) & ~(single_chan & play_act);
    assign cap_ack_sel = single_chan ? play_ack : cap_ack;

    dmarq_chan #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .act(cap_act), .mode(mode), .len(xfer_len),
        .ready(cap_ready), .stb(bus_rd), .ack(cap_ack_sel),
        .pend(cap_pend), .tc(cap_tc)
    );

    dmarq_chan #(.CNT_W(CNT_W)) u_play (
        .clk(clk), .rst(rst), .act(play_act), .mode(mode), .len(xfer_len),
        .ready(play_ready), .stb(bus_wr), .ack(play_ack),
        .pend(play_pend), .tc(play_tc)
    );

    dmarq_irq u_irq (
        .clk(clk), .rst(rst), .tc_cap(cap_tc), .tc_play(play_tc),
        .int_ack(int_ack), .int_en(int_en), .irq(irq)
    );

    assign cap_drq  = ~single_chan & cap_pend;
    assign play_drq = play_pend | (single_chan & cap_pend);

    // R5
    single_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (single_chan && play_en && !play_pio) |=> !cap_pend);
    // R2
    pio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_pio && !single_chan) |=> !cap_drq);
endmodule

// File: tb/dma_req_gen_tb_top.sv
module dma_req_gen_tb_top;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap_en = 0, cap_pio = 0, play_en = 0, play_pio = 0, single_chan = 0;
    logic early_rel = 0, int_en = 0, int_ack = 0;
    logic [CW-1:0] xfer_len = CW'(3);
    logic cap_ready = 0, play_ready = 0, cap_ack = 0, play_ack = 0;
    logic bus_rd = 0, bus_wr = 0;
    logic cap_drq, play_drq, irq;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dma_req_gen #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_pio(cap_pio),
        .play_en(play_en), .play_pio(play_pio), .single_chan(single_chan),
        .early_rel(early_rel), .int_en(int_en), .int_ack(int_ack),
        .xfer_len(xfer_len), .cap_ready(cap_ready), .play_ready(play_ready),
        .cap_ack(cap_ack), .play_ack(play_ack), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .cap_drq(cap_drq), .play_drq(play_drq), .irq(irq)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // {cap_en, cap_pio, play_en, play_pio, single, exp_cap_drq, exp_play_drq}
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_0_0_0_1_0,   // R1
        7'b1_1_0_0_0_0_0,   // R2
        7'b0_0_0_0_0_0_0,   // R3
        7'b0_0_1_0_0_0_1,   // R4
        7'b0_0_1_1_0_0_0,   // R4 pio
        7'b1_0_0_0_1_0_1,   // R5 capture folded
        7'b1_0_1_0_1_0_1,   // R5 both
        7'b1_0_1_0_0_1_1    // R1 R4 dual
    };

    task automatic pulse_ready(input logic c, input logic p);
        @(negedge clk); cap_ready = c; play_ready = p;
        @(negedge clk); cap_ready = 0; play_ready = 0;
    endtask

    task automatic byte_wr(output logic after_rise, output logic after_fall);
        @(negedge clk); bus_wr = 1;
        @(negedge clk); after_rise = play_drq; bus_wr = 0;
        @(negedge clk); after_fall = play_drq;
    endtask

    task automatic byte_rd(output logic after_rise, output logic after_fall);
        @(negedge clk); bus_rd = 1;
        @(negedge clk); after_rise = cap_drq; bus_rd = 0;
        @(negedge clk); after_fall = cap_drq;
    endtask

    initial begin
        logic r, f;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cap_drq, 1'b0, "R3 reset cap_drq");
        chk(play_drq, 1'b0, "R4 reset play_drq");
        chk(irq, 1'b0, "R8 reset irq");

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {cap_en, cap_pio, play_en, play_pio, single_chan} = VEC[i][6:2];
            pulse_ready(1'b1, 1'b1);
            chk(cap_drq, VEC[i][1], $sformatf("R1 R5 row %0d cap_drq", i));
            chk(play_drq, VEC[i][0], $sformatf("R4 R5 row %0d play_drq", i));
            {cap_en, cap_pio, play_en, play_pio, single_chan} = '0;
            repeat (2) @(negedge clk);
            chk(cap_drq | play_drq, 1'b0, "R3 disable clears");
        end

        // early release, playback, 3-byte transfer
        int_en = 1; early_rel = 1; play_ack = 1; play_en = 1;
        pulse_ready(1'b0, 1'b1);
        chk(play_drq, 1'b1, "R10 raised by ready");
        byte_wr(r, f);
        chk(r, 1'b1, "R6 held at byte1 rise");
        chk(f, 1'b1, "R6 held at byte1 fall");
        byte_wr(r, f);
        chk(r, 1'b0, "R6 drop at next-to-last rise");
        chk(irq, 1'b0, "R9 no irq before last");
        byte_wr(r, f);
        chk(irq, 1'b1, "R9 irq at terminal count");
        int_en = 0; #1;
        chk(irq, 1'b0, "R8 gated low");
        int_en = 1; #1;
        chk(irq, 1'b1, "R8 status shown");
        @(negedge clk); int_ack = 1;
        @(negedge clk); int_ack = 0;
        chk(irq, 1'b0, "R9 cleared by ack");

        // late release; counter was reloaded to 3
        early_rel = 0;
        pulse_ready(1'b0, 1'b1);
        byte_wr(r, f);
        byte_wr(r, f);
        chk(r, 1'b1, "R7 held at byte2 rise");
        chk(f, 1'b1, "R7 held at byte2 fall");
        byte_wr(r, f);
        chk(r, 1'b1, "R7 held at last rise");
        chk(f, 1'b0, "R7 drop at last fall");
        chk(irq, 1'b1, "R9 reload and second terminal");
        repeat (3) @(negedge clk);
        chk(play_drq, 1'b0, "R10 stays low without ready");
        pulse_ready(1'b0, 1'b1);
        chk(play_drq, 1'b1, "R10 re-raised");
        play_en = 0; play_ack = 0;
        @(negedge clk); int_ack = 1;
        @(negedge clk); int_ack = 0;

        // capture in PIO: strobes ignored
        cap_en = 1; cap_pio = 1; cap_ack = 1;
        pulse_ready(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) byte_rd(r, f);
        chk(cap_drq, 1'b0, "R2 no capture request in pio");
        chk(irq, 1'b0, "R2 pio strobes not counted");

        // capture DMA, late mode, counts via bus_rd
        cap_pio = 0;
        @(negedge clk);
        pulse_ready(1'b1, 1'b0);
        chk(cap_drq, 1'b1, "R1 capture dma request");
        byte_rd(r, f);
        byte_rd(r, f);
        chk(irq, 1'b0, "R1 no irq after two bytes");
        byte_rd(r, f);
        chk(f, 1'b0, "R7 capture drop at last fall");
        chk(irq, 1'b1, "R1 capture bytes counted");
        cap_en = 0; cap_ack = 0;

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule